// File: doc/BRIEF.md
# Byte-masked page transfer controller for a one-time-programmable array

The block puts a small register front end in front of a 512-page array whose pages are 128 bits wide. Software fills four 32-bit data words and a 16-bit byte-lane mask. It then writes a control word that carries a page number and two command bits. One command copies the data words into the page. The other copies the page back into the data words. Only the byte lanes whose mask bit is set move. Disabled lanes keep whatever the destination already held.

Every control write raises a sticky completion flag. The flag drives an interrupt line until software clears it by writing a one. A timing word is held for software but has no effect on the array. Accesses use a simple request/response bus. Every request is answered exactly one cycle later, and an unknown offset or a wrong access size is answered with an error.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, the byte mask reads 0xFFFF, the status reads 0x0000, the timing word reads 0x00001485, all data words read 0, every page holds zeros, and `irq` is low.
- R2: A control write with bit 12 set copies byte i of the data group into byte i of the page named by bits 8:0, for each i whose mask bit is 1. Other page bytes keep their previous value. Byte i is bits 8*(i mod 4)+7 down to 8*(i mod 4) of data word i/4, and the data words sit at offsets 0x80, 0x84, 0x88 and 0x8C.
- R3: A control write with bit 13 set copies byte i of the selected page into byte i of the data group, for each enabled lane. Disabled data bytes are unchanged.
- R4: When bits 12 and 13 are both set, the page is written first and the read then returns the updated page contents.
- R5: The control word at offset 0x00 keeps only bits 8:0 and bit 11 of a written value. The command bits 12 and 13 always read back as 0.
- R6: Every accepted control write sets status bit 0 (offset 0x08), whether or not a command bit is set. `irq` is high exactly while that bit is 1.
- R7: Writing status clears each bit that is written as 1 and leaves the other bits unchanged.
- R8: The byte mask (offset 0x04, 16 bits) and the timing word (offset 0x0C) are plain read/write registers. The data words are plain read/write registers as well.
- R9: An access to any other offset, or a 32-bit access to a 16-bit register (offsets 0x00, 0x04, 0x08), or a 16-bit access to a 32-bit register (0x0C, 0x80 to 0x8C), returns `rsp_err` high with read data 0 and changes no state.
- R10: Every request gets exactly one response, in the cycle after the request. A 16-bit read returns its value in bits 15:0 with bits 31:16 zero, and a write response carries data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Access request, valid for one cycle |
| we | input | 1 | 1 = write, 0 = read |
| sz32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data; 16-bit writes use bits 15:0 |
| rsp_vld | output | 1 | Response valid, one cycle after `req` |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data of the response |
| irq | output | 1 | High while the completion flag is set |

## Verification
The page write and the page read can fall in the same control write. The bench provokes this by loading a page with one pattern and then loading the data words with a second pattern. It then issues a combined command under a mask that enables some lanes of each word and disables the rest. The enabled lanes must come back holding the new data, and the disabled lanes must keep the old data words. A later full-mask read of the same page then shows whether the write really landed before the read. The second overlap is the completion flag: a status write can clear it while a control write in a neighbouring cycle sets it again. The behavioural model tracks this every cycle through the `irq` comparison.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h08;
  localparam logic [7:0] OFS_TIME  = 8'h0C;
  localparam logic [7:0] OFS_DATA0 = 8'h80;

  localparam int CMD_WR_BIT = 12;
  localparam int CMD_RD_BIT = 13;
  localparam int DONE_BIT   = 0;

  localparam logic [15:0] CTRL_KEEP  = 16'h09FF;
  localparam logic [15:0] MASK_RESET = 16'hFFFF;
  localparam logic [31:0] TIME_RESET = 32'h0000_1485;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MASK,
    SEL_STAT,
    SEL_TIME,
    SEL_DATA
  } reg_sel_e;

endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_WORDS = 4,
  localparam int IDX_W     = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sz32,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  word_idx,
  output logic              size_ok
);

  always_comb begin
    sel      = SEL_NONE;
    word_idx = '0;
    if (addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_TIME)) sel = SEL_TIME;
    else begin
      for (int w = 0; w < DATA_WORDS; w++) begin
        if (addr == ADDR_W'(int'(OFS_DATA0) + 4 * w)) begin
          sel      = SEL_DATA;
          word_idx = IDX_W'(w);
        end
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL, SEL_MASK, SEL_STAT: size_ok = !sz32;
      SEL_TIME, SEL_DATA:           size_ok = sz32;
      default:                      size_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/otp_byte_merge.sv
module otp_byte_merge #(
  parameter int NBYTES = 16,
  localparam int W     = 8 * NBYTES
) (
  input  logic [NBYTES-1:0] lane_en,
  input  logic [W-1:0]      keep_val,
  input  logic [W-1:0]      new_val,
  output logic [W-1:0]      merged
);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign merged[8*i +: 8] = lane_en[i] ? new_val[8*i +: 8] : keep_val[8*i +: 8];
  end

endmodule

// File: rtl/otp_page_store.sv
module otp_page_store #(
  parameter int PAGES  = 512,
  parameter int PAGE_W = 128,
  localparam int AW    = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     pg_addr,
  output logic [PAGE_W-1:0] pg_rdata,
  input  logic              pg_we,
  input  logic [PAGE_W-1:0] pg_wdata
);

  logic [PAGE_W-1:0] mem [PAGES];
  logic [PAGES-1:0]  written_q;
  logic [PAGES-1:0]  written_d;

  assign pg_rdata = written_q[pg_addr] ? mem[pg_addr] : '0;

  always_comb begin
    written_d = written_q;
    if (pg_we) written_d[pg_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written_q <= '0;
    else if (pg_we) written_q <= written_d;
  end

  always_ff @(posedge clk) begin
    if (pg_we) mem[pg_addr] <= pg_wdata;
  end

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int PAGES      = 512,
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 8,
  localparam int PAGE_W     = 8 * PAGE_BYTES,
  localparam int DATA_WORDS = PAGE_BYTES / 4,
  localparam int PAGE_AW    = $clog2(PAGES),
  localparam int IDX_W      = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              sz32,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ok_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ok_q   <= rst_meta_q;
    end
  end

  reg_sel_e         sel;
  logic [IDX_W-1:0] word_idx;
  logic             size_ok;

  otp_reg_decode #(.ADDR_W(ADDR_W), .DATA_WORDS(DATA_WORDS)) u_dec (
    .addr     (addr),
    .sz32     (sz32),
    .sel      (sel),
    .word_idx (word_idx),
    .size_ok  (size_ok)
  );

  logic [15:0]       ctrl_q, ctrl_d;
  logic [15:0]       mask_q, mask_d;
  logic [15:0]       stat_q, stat_d;
  logic [31:0]       time_q, time_d;
  logic [PAGE_W-1:0] data_q, data_d;
  logic              rsp_vld_d, rsp_err_d;
  logic [31:0]       rsp_rdata_d;

  logic              acc_ok, wr_ok, rd_ok, ctrl_wr;
  logic              do_pg_wr, do_pg_rd;
  logic              ctrl_en, mask_en, stat_en, time_en, data_en;
  logic [PAGE_AW-1:0] pg_sel;
  logic [PAGE_W-1:0] pg_old, pg_merged, pg_view, data_merged;

  assign acc_ok   = req && size_ok && (sel != SEL_NONE);
  assign wr_ok    = acc_ok && we;
  assign rd_ok    = acc_ok && !we;
  assign ctrl_wr  = wr_ok && (sel == SEL_CTRL);
  assign do_pg_wr = ctrl_wr && wdata[CMD_WR_BIT];
  assign do_pg_rd = ctrl_wr && wdata[CMD_RD_BIT];
  assign pg_sel   = wdata[PAGE_AW-1:0];

  otp_page_store #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_ok_q),
    .pg_addr  (pg_sel),
    .pg_rdata (pg_old),
    .pg_we    (do_pg_wr),
    .pg_wdata (pg_merged)
  );

  // data -> page under the lane mask
  otp_byte_merge #(.NBYTES(PAGE_BYTES)) u_merge_wr (
    .lane_en  (mask_q),
    .keep_val (pg_old),
    .new_val  (data_q),
    .merged   (pg_merged)
  );

  // page (after any write in the same command) -> data under the lane mask
  assign pg_view = do_pg_wr ? pg_merged : pg_old;

  otp_byte_merge #(.NBYTES(PAGE_BYTES)) u_merge_rd (
    .lane_en  (mask_q),
    .keep_val (data_q),
    .new_val  (pg_view),
    .merged   (data_merged)
  );

  // next-state logic
  always_comb begin
    ctrl_en = ctrl_wr;
    mask_en = wr_ok && (sel == SEL_MASK);
    time_en = wr_ok && (sel == SEL_TIME);
    stat_en = ctrl_wr || (wr_ok && (sel == SEL_STAT));
    data_en = do_pg_rd || (wr_ok && (sel == SEL_DATA));

    ctrl_d = wdata[15:0] & CTRL_KEEP;
    mask_d = wdata[15:0];
    time_d = wdata;

    stat_d = stat_q;
    if (wr_ok && (sel == SEL_STAT)) stat_d = stat_q & ~wdata[15:0];
    if (ctrl_wr) stat_d[DONE_BIT] = 1'b1;

    data_d = data_q;
    if (do_pg_rd) data_d = data_merged;
    else data_d[32*word_idx +: 32] = wdata;
  end

  always_comb begin
    rsp_vld_d   = req;
    rsp_err_d   = req && !acc_ok;
    rsp_rdata_d = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_CTRL: rsp_rdata_d = {16'h0, ctrl_q};
        SEL_MASK: rsp_rdata_d = {16'h0, mask_q};
        SEL_STAT: rsp_rdata_d = {16'h0, stat_q};
        SEL_TIME: rsp_rdata_d = time_q;
        SEL_DATA: rsp_rdata_d = data_q[32*word_idx +: 32];
        default:  rsp_rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) begin
      ctrl_q    <= '0;
      mask_q    <= MASK_RESET;
      stat_q    <= '0;
      time_q    <= TIME_RESET;
      data_q    <= '0;
      rsp_vld   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (mask_en) mask_q <= mask_d;
      if (stat_en) stat_q <= stat_d;
      if (time_en) time_q <= time_d;
      if (data_en) data_q <= data_d;
      rsp_vld   <= rsp_vld_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  assign irq = stat_q[DONE_BIT];

endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        req,
  input logic        we,
  input logic        sz32,
  input logic [7:0]  addr,
  input logic [31:0] wdata,
  input logic        rsp_vld,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        irq
);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    req |=> rsp_vld);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !req |=> !rsp_vld);

  // R6
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && we && !sz32 && addr == 8'h00) |=> irq);

  // R7
  w1c_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && we && !sz32 && addr == 8'h08 && wdata[0]) |=> !irq);

  // R5
  cmd_bits_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && !we && !sz32 && addr == 8'h00) |=> (rsp_rdata[13:12] == 2'b00));

  // R9
  bad_offset_err_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && addr == 8'h10) |=> (rsp_err && rsp_rdata == 32'h0));

  // R9
  bad_size_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && we && sz32 && addr == 8'h00) |=> (rsp_err && $stable(irq)));

endmodule

bind otp_page_ctrl otp_page_ctrl_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok_q),
  .req       (req),
  .we        (we),
  .sz32      (sz32),
  .addr      (addr),
  .wdata     (wdata),
  .rsp_vld   (rsp_vld),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .irq       (irq)
);

// File: tb/otp_page_ctrl_tb.sv
`timescale 1ns/1ps
module otp_page_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sz32 = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_vld, rsp_err, irq;
  logic [31:0] rsp_rdata;

  always #5 clk = ~clk;

  otp_page_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .sz32(sz32),
    .addr(addr), .wdata(wdata), .rsp_vld(rsp_vld), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  bit [7:0]  pm [512][16];
  bit [7:0]  dm [16];
  bit [15:0] m_ctrl, m_mask, m_stat;
  bit [31:0] m_time;
  bit        e_vld, e_err;
  bit [31:0] e_rdata;
  string     e_tag;

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bit [31:0] dword(int w);
    return {dm[4*w+3], dm[4*w+2], dm[4*w+1], dm[4*w]};
  endfunction

  task automatic model_step(bit r, bit w, bit s, bit [7:0] a, bit [31:0] d, string tag);
    int need;
    bit known;
    e_vld = r; e_err = 1'b0; e_rdata = '0; e_tag = tag;
    if (!r) return;
    known = 1'b1;
    case (a)
      8'h00, 8'h04, 8'h08: need = 0;
      8'h0C, 8'h80, 8'h84, 8'h88, 8'h8C: need = 1;
      default: known = 1'b0;
    endcase
    if (!known || int'(s) != need) begin
      e_err = 1'b1;
      return;
    end
    if (!w) begin
      case (a)
        8'h00: e_rdata = {16'h0, m_ctrl};
        8'h04: e_rdata = {16'h0, m_mask};
        8'h08: e_rdata = {16'h0, m_stat};
        8'h0C: e_rdata = m_time;
        default: e_rdata = dword((int'(a) - 'h80) / 4);
      endcase
      return;
    end
    case (a)
      8'h00: begin
        int pg;
        pg = int'(d[8:0]);
        m_ctrl = d[15:0] & 16'h09FF;
        if (d[12]) for (int i = 0; i < 16; i++) if (m_mask[i]) pm[pg][i] = dm[i];
        if (d[13]) for (int i = 0; i < 16; i++) if (m_mask[i]) dm[i] = pm[pg][i];
        m_stat[0] = 1'b1;
      end
      8'h04: m_mask = d[15:0];
      8'h08: m_stat = m_stat & ~d[15:0];
      8'h0C: m_time = d;
      default: begin
        int wi;
        wi = (int'(a) - 'h80) / 4;
        for (int b = 0; b < 4; b++) dm[4*wi+b] = d[8*b +: 8];
      end
    endcase
  endtask

  // one clock: compare outputs of the previous edge, then drive the next request
  task automatic cyc(bit r, bit w, bit s, bit [7:0] a, bit [31:0] d, string tag);
    @(negedge clk);
    check("R10", "rsp_vld", rsp_vld, e_vld);
    if (e_vld) begin
      check(e_err ? "R9" : e_tag, "rsp_err", rsp_err, e_err);
      check(e_err ? "R9" : e_tag, "rsp_rdata", rsp_rdata, e_rdata);
    end
    check("R6", "irq", irq, m_stat[0]);
    req = r; we = w; sz32 = s; addr = a; wdata = d;
    model_step(r, w, s, a, d, tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 8'h00, 32'h0, "R10");
  endtask

  task automatic wr16(bit [7:0] a, bit [15:0] v, string t); cyc(1, 1, 0, a, {16'h0, v}, t); endtask
  task automatic rd16(bit [7:0] a, string t);               cyc(1, 0, 0, a, 32'h0, t);         endtask
  task automatic wr32(bit [7:0] a, bit [31:0] v, string t); cyc(1, 1, 1, a, v, t);              endtask
  task automatic rd32(bit [7:0] a, string t);               cyc(1, 0, 1, a, 32'h0, t);         endtask

  task automatic load_data(bit [31:0] base, string t);
    for (int w = 0; w < 4; w++) wr32(8'(8'h80 + 4 * w), base ^ (32'h1111_1111 * w), t);
  endtask

  task automatic read_data(string t);
    for (int w = 0; w < 4; w++) rd32(8'(8'h80 + 4 * w), t);
  endtask

  initial begin
    m_mask = 16'hFFFF; m_time = 32'h0000_1485; m_ctrl = '0; m_stat = '0;
    e_vld = 0; e_err = 0; e_rdata = '0; e_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: reset values
    rd16(8'h00, "R1"); rd16(8'h04, "R1"); rd16(8'h08, "R1"); rd32(8'h0C, "R1");
    read_data("R1");

    // R2: full-mask page write then R3 read back after clobbering the data words
    load_data(32'hA1B2_C3D4, "R8");
    read_data("R8");
    wr16(8'h00, 16'h1005, "R2");
    rd16(8'h08, "R6");
    wr16(8'h08, 16'h0000, "R7");
    rd16(8'h08, "R7");
    wr16(8'h08, 16'h0001, "R7");
    rd16(8'h08, "R7");
    load_data(32'h0, "R8");
    wr16(8'h00, 16'h2005, "R3");
    read_data("R2");

    // R3: masked page read
    load_data(32'h5555_AAAA, "R8");
    wr16(8'h04, 16'h0F0F, "R8");
    rd16(8'h04, "R8");
    wr16(8'h00, 16'h2005, "R3");
    read_data("R3");

    // R2: masked page write over existing page, then full read
    load_data(32'hDEAD_BEEF, "R8");
    wr16(8'h04, 16'hA5A5, "R8");
    wr16(8'h00, 16'h1005, "R2");
    wr16(8'h04, 16'hFFFF, "R8");
    load_data(32'h0, "R8");
    wr16(8'h00, 16'h2005, "R2");
    read_data("R2");

    // R4: combined write and read on page 300
    load_data(32'h0102_0304, "R8");
    wr16(8'h00, 16'h112C, "R4");
    load_data(32'hF0E0_D0C0, "R8");
    wr16(8'h04, 16'h3C3C, "R8");
    wr16(8'h00, 16'h312C, "R4");
    read_data("R4");
    wr16(8'h04, 16'hFFFF, "R8");
    load_data(32'h0, "R8");
    wr16(8'h00, 16'h212C, "R4");
    read_data("R4");

    // R5: control masking, last page, both commands, then a command-free write
    load_data(32'h7777_0001, "R8");
    wr16(8'h00, 16'hFFFF, "R5");
    rd16(8'h00, "R5");
    wr16(8'h08, 16'hFFFF, "R7");
    rd16(8'h08, "R7");
    wr16(8'h00, 16'h0000, "R6");
    rd16(8'h08, "R6");
    rd16(8'h00, "R5");
    load_data(32'h0, "R8");
    wr16(8'h00, 16'h21FF, "R5");
    read_data("R5");

    // R8: timing and mask read/write
    wr32(8'h0C, 32'hCAFE_F00D, "R8");
    rd32(8'h0C, "R8");
    wr16(8'h04, 16'h1234, "R8");
    rd16(8'h04, "R8");
    wr16(8'h04, 16'hFFFF, "R8");

    // R9: invalid offsets and sizes, with no effect
    wr16(8'h08, 16'h0001, "R7");
    cyc(1, 1, 1, 8'h00, 32'h0000_1005, "R9");
    rd16(8'h08, "R9");
    cyc(1, 1, 0, 8'h80, 32'h0000_FFFF, "R9");
    cyc(1, 1, 1, 8'h10, 32'hFFFF_FFFF, "R9");
    cyc(1, 1, 1, 8'h81, 32'hFFFF_FFFF, "R9");
    cyc(1, 0, 1, 8'h04, 32'h0, "R9");
    cyc(1, 0, 0, 8'h0C, 32'h0, "R9");
    cyc(1, 1, 0, 8'h40, 32'h0000_0001, "R9");
    rd32(8'h80, "R9");
    rd16(8'h04, "R9");
    rd32(8'h0C, "R9");
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule